// File: doc/BRIEF.md
# Double-Buffered Converter Register Controller

This block sits behind a serial receiver and in front of a digital-to-analog converter core. Each time the receiver finishes a transfer, it presents a 4-bit command and a 16-bit data field together with a one-cycle execute strobe. The block applies the command to a pair of registers. The staging register holds the next code. The output register drives the converter. The block also keeps the power-down state and models the wake-up settling time as a busy flag.

A separate active-low load pin moves the staging register into the output register without a command, and its meaning depends on the chip-select level. With select high, a low level on the pin copies the staging value to the output and wakes the converter. With select low, only a falling edge on the pin counts, and it wakes the converter without touching the output.

The resolution is a parameter. A narrower code is taken from the upper bits of the data field. Reset loads both registers with zero scale or midscale, chosen by a strap input.

Top module: `dac_reg_ctrl`

## Requirements
- R1: While reset is held and after it is released, both registers equal 0 when `mid_sel` is 0, or 2^(RES_BITS-1) when `mid_sel` is 1, and `pwr_down` and `busy` are 0.
- R2: Command 4'b0000 with the strobe loads the data code into the staging register only, and `dac_code` keeps its value.
- R3: Command 4'b0001 with the strobe copies the staging register to `dac_code` and clears `pwr_down`.
- R4: Command 4'b0011 with the strobe writes the data code to both registers in the same cycle and clears `pwr_down`.
- R5: Command 4'b0100 with the strobe sets `pwr_down`, ignores the data field, and leaves both registers unchanged.
- R6: Command 4'b1111 and every code other than 0000, 0001, 0011 and 0100 leave both registers and `pwr_down` unchanged.
- R7: Without a strobe, with `cs_n` high and `load_n` low, each clock copies the staging register to `dac_code` and clears `pwr_down`.
- R8: Without a strobe, with `cs_n` low, a high-to-low change of `load_n` clears `pwr_down` and leaves `dac_code` unchanged.
- R9: A change of `pwr_down` from 1 to 0 raises `busy` for exactly WAKE cycles. WAKE is `WAKE_CYC_LOW` when `LOW_SUPPLY` is 1 and `WAKE_CYC_HIGH` otherwise. A wake command that arrives while the converter is already powered does not restart `busy`, and entering power-down clears it.
- R10: The code is data[15:16-RES_BITS], and the lower data bits have no effect.
- R11: A strobe in the same cycle as a load-pin event wins. The load-pin event is applied in the next cycle.
- R12: Every register change caused by a strobe or by the load pin is visible one clock edge after the cycle in which it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mid_sel | input | 1 | Reset value strap: 0 selects zero scale, 1 selects midscale |
| exec_stb | input | 1 | One-cycle execute strobe for `cmd` and `data` |
| cmd | input | 4 | Command code |
| data | input | 16 | Data field, code left-aligned |
| cs_n | input | 1 | Chip-select level (low = transfer in progress) |
| load_n | input | 1 | Active-low load pin, synchronous to `clk` |
| dac_code | output | RES_BITS | Output register value |
| pwr_down | output | 1 | Converter powered down |
| busy | output | 1 | Wake-up settling in progress |

## Verification
An execute strobe and a load-pin event can arrive in the same cycle, and the bench makes this happen on purpose. In one case a staging write meets a select-low falling edge while the converter is powered down. In the other, a power-down command meets a select-high level load. The bench checks that the first edge shows only the command's effect and that the second edge shows the deferred load action. A reference model in the bench tracks the registers, the power state and the wake counter cycle by cycle while all sixteen command codes are swept.

// File: rtl/dac_ctl_pkg.sv
`timescale 1ns/1ps
package dac_ctl_pkg;

  typedef enum logic [3:0] {
    OP_STAGE        = 4'h0,
    OP_COMMIT       = 4'h1,
    OP_STAGE_COMMIT = 4'h3,
    OP_SLEEP        = 4'h4,
    OP_NONE         = 4'hF
  } op_e;

  typedef struct packed {
    logic wr_stage;
    logic commit;
    logic use_new;
    logic wake;
    logic sleep;
  } act_t;

  localparam act_t ACT_IDLE = '{wr_stage: 1'b0, commit: 1'b0, use_new: 1'b0,
                                wake: 1'b0, sleep: 1'b0};

  function automatic act_t decode_op(input logic [3:0] code);
    act_t a;
    a = ACT_IDLE;
    case (code)
      OP_STAGE:        a.wr_stage = 1'b1;
      OP_COMMIT:       begin a.commit = 1'b1; a.wake = 1'b1; end
      OP_STAGE_COMMIT: begin
        a.wr_stage = 1'b1;
        a.commit   = 1'b1;
        a.use_new  = 1'b1;
        a.wake     = 1'b1;
      end
      OP_SLEEP:        a.sleep = 1'b1;
      default:         a = ACT_IDLE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dac_rst_sync.sv
`timescale 1ns/1ps
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
`timescale 1ns/1ps
module dac_cmd_decode
  import dac_ctl_pkg::*;
(
  input  logic       exec_stb,
  input  logic [3:0] cmd,
  output act_t       act
);
  always_comb begin
    if (exec_stb) act = decode_op(cmd);
    else          act = ACT_IDLE;
  end
endmodule

// File: rtl/dac_load_pin.sv
`timescale 1ns/1ps
module dac_load_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_stb,
  input  logic cs_n,
  input  logic load_n,
  output logic ld_commit,
  output logic ld_wake
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic fall;
  logic level_req;
  logic edge_req;

  always_comb begin
    fall      = prev_q & ~load_n;
    level_req = cs_n & ~load_n;
    edge_req  = ~cs_n & fall;
    prev_d    = load_n;
    // a select-low edge lost to a strobe is held for one cycle
    pend_d    = exec_stb & edge_req;
    ld_commit = ~exec_stb & level_req;
    ld_wake   = ~exec_stb & (level_req | edge_req | pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dac_reg_pair.sv
`timescale 1ns/1ps
module dac_reg_pair #(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mid_sel,
  input  logic                wr_stage,
  input  logic                commit,
  input  logic                use_new,
  input  logic [RES_BITS-1:0] new_code,
  output logic [RES_BITS-1:0] stage_q,
  output logic [RES_BITS-1:0] out_q
);
  localparam logic [RES_BITS-1:0] MID_CODE  = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam logic [RES_BITS-1:0] ZERO_CODE = '0;

  logic [RES_BITS-1:0] stage_d;
  logic [RES_BITS-1:0] out_d;
  logic                stage_en;
  logic                out_en;

  always_comb begin
    stage_en = wr_stage;
    out_en   = commit;
    stage_d  = new_code;
    out_d    = use_new ? new_code : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= mid_sel ? MID_CODE : ZERO_CODE;
      out_q   <= mid_sel ? MID_CODE : ZERO_CODE;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (out_en)   out_q   <= out_d;
    end
  end
endmodule

// File: rtl/dac_wake_timer.sv
`timescale 1ns/1ps
module dac_wake_timer #(
  parameter int WAKE_CYC = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic wake,
  output logic pd_q,
  output logic busy
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYC);

  logic          pd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    pd_d  = pd_q;
    cnt_d = cnt_q;
    if (sleep) begin
      pd_d  = 1'b1;
      cnt_d = '0;
    end else if (wake && pd_q) begin
      pd_d  = 1'b0;
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    cnt_en = sleep | wake | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      pd_q <= pd_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dac_reg_ctrl.sv
`timescale 1ns/1ps
module dac_reg_ctrl
  import dac_ctl_pkg::*;
#(
  parameter int RES_BITS      = 16,
  parameter int WAKE_CYC_HIGH = 2400,
  parameter int WAKE_CYC_LOW  = 6000,
  parameter bit LOW_SUPPLY    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mid_sel,
  input  logic                exec_stb,
  input  logic [3:0]          cmd,
  input  logic [15:0]         data,
  input  logic                cs_n,
  input  logic                load_n,
  output logic [RES_BITS-1:0] dac_code,
  output logic                pwr_down,
  output logic                busy
);
  localparam int FIELD_W = 16;

  logic                rst_sync_n;
  act_t                act;
  logic                ld_commit, ld_wake;
  logic                do_commit, do_wake;
  logic [RES_BITS-1:0] new_code;
  logic [RES_BITS-1:0] stage_q;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dac_cmd_decode u_dec (
    .exec_stb(exec_stb), .cmd(cmd), .act(act)
  );

  dac_load_pin u_ld (
    .clk(clk), .rst_n(rst_sync_n), .exec_stb(exec_stb),
    .cs_n(cs_n), .load_n(load_n),
    .ld_commit(ld_commit), .ld_wake(ld_wake)
  );

  generate
    if (RES_BITS == FIELD_W) begin : g_full
      assign new_code = data;
    end else begin : g_narrow
      assign new_code = data[FIELD_W-1 -: RES_BITS];
    end
  endgenerate

  always_comb begin
    do_commit = act.commit | ld_commit;
    do_wake   = act.wake | ld_wake;
  end

  dac_reg_pair #(.RES_BITS(RES_BITS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .mid_sel(mid_sel),
    .wr_stage(act.wr_stage), .commit(do_commit), .use_new(act.use_new),
    .new_code(new_code), .stage_q(stage_q), .out_q(dac_code)
  );

  generate
    if (LOW_SUPPLY) begin : g_wake_low
      dac_wake_timer #(.WAKE_CYC(WAKE_CYC_LOW)) u_wake (
        .clk(clk), .rst_n(rst_sync_n), .sleep(act.sleep), .wake(do_wake),
        .pd_q(pwr_down), .busy(busy)
      );
    end else begin : g_wake_high
      dac_wake_timer #(.WAKE_CYC(WAKE_CYC_HIGH)) u_wake (
        .clk(clk), .rst_n(rst_sync_n), .sleep(act.sleep), .wake(do_wake),
        .pd_q(pwr_down), .busy(busy)
      );
    end
  endgenerate
endmodule

// File: rtl/dac_reg_ctrl_chk.sv
`timescale 1ns/1ps
module dac_reg_ctrl_chk #(
  parameter int RES_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                exec_stb,
  input logic [3:0]          cmd,
  input logic [15:0]         data,
  input logic                cs_n,
  input logic                load_n,
  input logic [RES_BITS-1:0] stage_q,
  input logic [RES_BITS-1:0] dac_code,
  input logic                pwr_down,
  input logic                busy
);
  logic [RES_BITS-1:0] slice;
  logic                known;
  assign slice = data[15 -: RES_BITS];
  assign known = (cmd == 4'h0) || (cmd == 4'h1) || (cmd == 4'h3) || (cmd == 4'h4);

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd == 4'h0 |=> $stable(dac_code) && stage_q == $past(slice));

  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd == 4'h1 |=> dac_code == $past(stage_q) && !pwr_down);

  assert_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd == 4'h3 |=> dac_code == $past(slice) && stage_q == $past(slice) && !pwr_down);

  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd == 4'h4 |=> pwr_down && $stable(dac_code) && $stable(stage_q));

  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && !known |=> $stable(dac_code) && $stable(stage_q) && $stable(pwr_down));

  assert_level_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb && cs_n && !load_n |=> dac_code == $past(stage_q) && !pwr_down);

  assert_busy_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pwr_down);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_down));

  assert_strobe_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && cmd == 4'h0 && pwr_down |=> pwr_down);
endmodule

bind dac_reg_ctrl dac_reg_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .exec_stb(exec_stb), .cmd(cmd), .data(data),
  .cs_n(cs_n), .load_n(load_n), .stage_q(stage_q), .dac_code(dac_code),
  .pwr_down(pwr_down), .busy(busy)
);

// File: tb/dac_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_reg_ctrl_tb_top;
  localparam int RES   = 12;
  localparam int WAKE  = 7;
  localparam logic [RES-1:0] MID = 12'h800;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mid_sel = 1'b0;
  logic           exec_stb = 1'b0;
  logic [3:0]     cmd = 4'hF;
  logic [15:0]    data = '0;
  logic           cs_n = 1'b1;
  logic           load_n = 1'b1;
  logic [RES-1:0] dac_code;
  logic           pwr_down;
  logic           busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [RES-1:0] m_stage, m_dac;
  bit             m_pd, m_pend, m_prev;
  int             m_cnt;

  always #2.5 clk = ~clk;

  dac_reg_ctrl #(
    .RES_BITS(RES), .WAKE_CYC_HIGH(4), .WAKE_CYC_LOW(WAKE), .LOW_SUPPLY(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .exec_stb(exec_stb),
    .cmd(cmd), .data(data), .cs_n(cs_n), .load_n(load_n),
    .dac_code(dac_code), .pwr_down(pwr_down), .busy(busy)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    total++;
    if (dac_code !== m_dac || pwr_down !== m_pd || busy !== (m_cnt != 0)) begin
      bad++;
      $display("FAIL %s actual=dac %0h pd %0b busy %0b expected=dac %0h pd %0b busy %0b",
               tag, dac_code, pwr_down, busy, m_dac, m_pd, m_cnt != 0);
    end
  endtask

  task automatic model_step(input bit ex, input logic [3:0] c, input logic [15:0] d,
                            input bit csn, input bit ldn);
    bit wk = 0, sl = 0, fall;
    logic [RES-1:0] code = d[15:16-RES];
    fall = m_prev && !ldn;
    if (ex) begin
      case (c)
        4'h0: m_stage = code;
        4'h1: begin m_dac = m_stage; wk = 1; end
        4'h3: begin m_stage = code; m_dac = code; wk = 1; end
        4'h4: sl = 1;
        default: ;
      endcase
      m_pend = !csn && fall;
    end else begin
      if (csn && !ldn) begin m_dac = m_stage; wk = 1; end
      if ((!csn && fall) || m_pend) wk = 1;
      m_pend = 0;
    end
    if (sl) begin m_pd = 1; m_cnt = 0; end
    else if (wk && m_pd) begin m_pd = 0; m_cnt = WAKE; end
    else if (m_cnt > 0) m_cnt--;
    m_prev = ldn;
  endtask

  task automatic tick(input bit ex, input logic [3:0] c, input logic [15:0] d,
                      input bit csn, input bit ldn, input string tag);
    @(negedge clk);
    exec_stb = ex; cmd = c; data = d; cs_n = csn; load_n = ldn;
    @(posedge clk);
    model_step(ex, c, d, csn, ldn);
    #1;
    check_model(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 4'hF, 16'h0, 1'b1, 1'b1, tag);
  endtask

  task automatic do_reset(input bit mid);
    @(negedge clk);
    rst_n = 1'b0; mid_sel = mid;
    exec_stb = 0; cs_n = 1; load_n = 1;
    repeat (3) @(negedge clk);
    m_stage = mid ? MID : '0; m_dac = m_stage;
    m_pd = 0; m_pend = 0; m_prev = 1; m_cnt = 0;
    #1;
    check_val("R1 reset dac", dac_code, m_dac);
    check_val("R1 reset pd/busy", {pwr_down, busy}, 0);
    rst_n = 1'b1;
    idle(3, "R1 after release");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tg;
    do_reset(1'b0);
    check_val("R1 zero scale", dac_code, 0);

    // sweep every command code from a known state, awake and asleep
    for (int sleepy = 0; sleepy < 2; sleepy++) begin
      for (int c = 0; c < 16; c++) begin
        logic [15:0] d0 = 16'(c * 16'h1111 ^ 16'h2493);
        logic [15:0] d1 = 16'(c * 16'h0F0D + 16'h5A5F);
        case (c)
          0: tg = "R2 cmd";
          1: tg = "R3 cmd";
          3: tg = "R4 cmd";
          4: tg = "R5 cmd";
          default: tg = "R6 cmd";
        endcase
        tick(1, 4'h3, d0, 1'b1, 1'b1, "R4 preload");
        tick(1, 4'h0, d1, 1'b1, 1'b1, "R2 restage");
        if (sleepy != 0) tick(1, 4'h4, 16'hFFFF, 1'b1, 1'b1, "R5 sleep");
        tick(1, 4'(c), ~d1, 1'b1, 1'b1, tg);
        idle(2, tg);
        tick(1, 4'h1, 16'h0, 1'b1, 1'b1, "R3 reveal stage");
        idle(WAKE + 1, "R9 settle");
      end
    end

    // resolution: low data bits ignored
    tick(1, 4'h3, 16'hABCF, 1'b1, 1'b1, "R10 narrow");
    check_val("R10 upper bits", dac_code, 12'hABC);
    tick(1, 4'h3, 16'hABC0, 1'b1, 1'b1, "R10 low bits");
    check_val("R10 low bits ignored", dac_code, 12'hABC);

    // wake timing
    tick(1, 4'h4, 16'h0, 1'b1, 1'b1, "R5 sleep");
    check_val("R5 pd set", pwr_down, 1);
    tick(1, 4'h1, 16'h0, 1'b1, 1'b1, "R9 wake");
    for (int i = 0; i < WAKE + 2; i++) begin
      check_val("R9 busy window", busy, (i < WAKE) ? 1 : 0);
      idle(1, "R9 window");
    end
    tick(1, 4'h1, 16'h0, 1'b1, 1'b1, "R9 no restart");
    check_val("R9 no restart when awake", busy, 0);

    // select-high level load
    tick(1, 4'h0, 16'h3210, 1'b1, 1'b1, "R7 stage");
    tick(1, 4'h4, 16'h0, 1'b1, 1'b1, "R7 sleep");
    tick(0, 4'hF, 16'h0, 1'b1, 1'b0, "R7 level load");
    check_val("R7 dac copy", dac_code, 12'h321);
    check_val("R7 awake", pwr_down, 0);
    idle(WAKE + 1, "R7 settle");

    // select-low falling edge wakes only
    tick(1, 4'h0, 16'h7770, 1'b1, 1'b1, "R8 stage");
    tick(1, 4'h4, 16'h0, 1'b1, 1'b1, "R8 sleep");
    tick(0, 4'hF, 16'h0, 1'b0, 1'b1, "R8 select");
    tick(0, 4'hF, 16'h0, 1'b0, 1'b0, "R8 edge");
    check_val("R8 awake", pwr_down, 0);
    check_val("R8 dac kept", dac_code, 12'h321);
    tick(0, 4'hF, 16'h0, 1'b0, 1'b0, "R8 held low");
    idle(WAKE + 1, "R8 settle");

    // collision: strobe beats select-low edge, edge applied next cycle
    tick(1, 4'h4, 16'h0, 1'b1, 1'b1, "R11 sleep");
    tick(0, 4'hF, 16'h0, 1'b0, 1'b1, "R11 select");
    tick(1, 4'h0, 16'h1230, 1'b0, 1'b0, "R11 collide edge");
    check_val("R11 strobe first", pwr_down, 1);
    tick(0, 4'hF, 16'h0, 1'b1, 1'b1, "R11 deferred edge");
    check_val("R11 deferred wake", pwr_down, 0);
    check_val("R11 dac kept", dac_code, 12'h321);
    idle(WAKE + 1, "R11 settle");

    // collision: sleep strobe beats select-high level load
    tick(1, 4'h3, 16'h4560, 1'b1, 1'b1, "R11 preload");
    tick(1, 4'h0, 16'h9990, 1'b1, 1'b1, "R11 stage");
    tick(1, 4'h4, 16'h0, 1'b1, 1'b0, "R11 collide level");
    check_val("R11 sleep wins", pwr_down, 1);
    check_val("R11 dac held", dac_code, 12'h456);
    tick(0, 4'hF, 16'h0, 1'b1, 1'b0, "R12 level next");
    check_val("R12 level applied", dac_code, 12'h999);
    check_val("R11 woke after", pwr_down, 0);
    idle(WAKE + 1, "R11 settle");

    // midscale reset
    do_reset(1'b1);
    check_val("R1 midscale dac", dac_code, MID);
    tick(1, 4'h1, 16'h0, 1'b1, 1'b1, "R1 stage midscale");
    check_val("R1 midscale stage", dac_code, MID);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule